// File: doc/BRIEF.md
# Branchless Byte Processing Element

A small synchronous 8-bit compute element meant to be tiled many times in a dataflow array. It runs a short, statically scheduled program held in a circular instruction buffer. There are no jumps. Every evaluation begins at instruction zero and steps forward one slot per instruction until it reaches a programmed end index. The program counter then returns to zero and the element waits for the next start pulse. Each instruction combines the latched result of the previous instruction with a second operand. That second operand is a 7-bit immediate or the value offered by one of three neighbouring elements.

The latched result drives the neighbour output continuously, so a downstream element can consume it. Local storage is an eight-entry register file and a data RAM. Any instruction that touches the data RAM spends one extra cycle compared with a register-file access. A host loads programs and data through a load port. While the load enable is high, execution is halted and both memories accept writes by address.

The sequencer has four states:
- IDLE: waiting for a start pulse.
- LOAD: host access.
- EXEC: an instruction is issued, and committed unless it touches the RAM.
- MEMW: the second cycle of a RAM instruction.

The transitions are:
- start: IDLE to EXEC, and also EXEC or MEMW back to EXEC at slot 0.
- step: EXEC to EXEC.
- stall: EXEC to MEMW.
- resume: MEMW to EXEC.
- finish: EXEC or MEMW to IDLE after the end index.
- halt: any state to LOAD while load enable is high.
- release: LOAD to IDLE.

Top module: `byte_pe`

## Requirements
- R1: After reset, `nb_out` is 0x00, `busy` is low and all eight registers read 0x00.
- R2: Instruction format: bits [15:12] are the opcode, [11:9] the register select, [8:7] the operand select, and [6:0] the immediate or RAM offset. Operand select 0 means the zero-extended immediate; 1, 2 and 3 mean `nb_in0`, `nb_in1` and `nb_in2`.
- R3: Opcodes 1 MOV, 2 AND, 3 OR and 4 XOR load the result latch with B, A&B, A|B and A^B respectively. A is the latched result and B is the selected operand.
- R4: Opcodes 6 SHL, 7 SHR, 8 ROL and 9 ROR shift or rotate the latched result by B[2:0] bit positions. The shifts fill with zeros.
- R5: Opcode 5 CEQ writes 0x01 to the latch when A equals B and 0x00 otherwise.
- R6: The latch drives `nb_out` and is the implicit A operand of the next instruction. It does not change while `busy` is low.
- R7: Opcode 11 WRR copies the latch into the selected register, and opcode 10 RDR loads the latch from the selected register.
- R8: Opcode 13 WRM stores the latch to the RAM and opcode 12 RDM loads the latch from the RAM. The RAM address is {low 3 bits of the selected register, offset}. Each RAM instruction takes two cycles; every other instruction takes one.
- R9: A start pulse puts the counter at 0. Instructions then run in order up to and including `end_idx`, after which `busy` falls. `busy` is high for exactly one cycle per non-RAM instruction plus two per RAM instruction.
- R10: A start pulse during a running evaluation restarts it from instruction 0.
- R11: While `load_en` is high, execution halts, `busy` is low and start pulses are ignored. With `ld_we` high, `ld_data` is written at `ld_addr`: into the instruction buffer when `ld_tgt`=0, and as its low byte into the RAM when `ld_tgt`=1.
- R12: Opcode 0 and opcodes 14 and 15 leave the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) an evaluation at instruction 0 |
| end_idx | input | 8 | Index of the last instruction of an evaluation |
| load_en | input | 1 | Halt execution and open memory loading |
| ld_we | input | 1 | Write strobe for the load port |
| ld_tgt | input | 1 | Load target: 0 instruction buffer, 1 data RAM |
| ld_addr | input | 10 | Load address |
| ld_data | input | 16 | Load data (RAM takes the low byte) |
| nb_in0 | input | 8 | Neighbour operand, select 1 |
| nb_in1 | input | 8 | Neighbour operand, select 2 |
| nb_in2 | input | 8 | Neighbour operand, select 3 |
| nb_out | output | 8 | Latched result offered to neighbours |
| busy | output | 1 | High while an evaluation is running |

## Verification
The bench builds the element with its default parameters: 8-bit data, a 256-slot instruction buffer and a 1024-byte RAM. With these values the RAM address uses all three page bits taken from a register. A RAM cell preloaded at the top page (0x3F7) can be read back through register paging, and the cycle count of runs that mix one-cycle and two-cycle instructions can be compared with the count predicted from R9. Rotations are checked where bits wrap across the byte edge. A halt and a restart are each applied in the middle of a running evaluation.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

    // Fixed 16-bit instruction layout: opcode | register | operand select | immediate
    localparam int INSTR_W = 16;
    localparam int IMM_W   = 7;
    localparam int RSEL_W  = 3;
    localparam int NSEL_W  = 2;
    localparam int NREG    = 1 << RSEL_W;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_MOV = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_CEQ = 4'd5,
        OP_SHL = 4'd6,
        OP_SHR = 4'd7,
        OP_ROL = 4'd8,
        OP_ROR = 4'd9,
        OP_RDR = 4'd10,
        OP_WRR = 4'd11,
        OP_RDM = 4'd12,
        OP_WRM = 4'd13,
        OP_R14 = 4'd14,
        OP_R15 = 4'd15
    } bpe_op_e;

    typedef struct packed {
        bpe_op_e             op;
        logic [RSEL_W-1:0]   rsel;
        logic [NSEL_W-1:0]   nsel;
        logic [IMM_W-1:0]    imm;
    } bpe_instr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EXEC = 2'd2,
        ST_MEMW = 2'd3
    } bpe_state_e;

endpackage

// File: rtl/bpe_imem.sv
module bpe_imem #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [AW-1:0]                waddr,
    input  logic [bpe_pkg::INSTR_W-1:0]  wdata,
    input  logic [AW-1:0]                raddr,
    output logic [bpe_pkg::INSTR_W-1:0]  rdata
);
    logic [bpe_pkg::INSTR_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slots[waddr] <= wdata;
        end
    end

    assign rdata = slots[raddr];
endmodule

// File: rtl/bpe_store.sv
module bpe_store #(
    parameter int DW       = 8,
    parameter int DM_DEPTH = 1024,
    localparam int DM_AW   = $clog2(DM_DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rf_we,
    input  logic [bpe_pkg::RSEL_W-1:0]  rf_sel,
    input  logic [DW-1:0]               rf_wdata,
    output logic [DW-1:0]               rf_rdata,
    input  logic                        dm_we,
    input  logic [DM_AW-1:0]            dm_addr,
    input  logic [DW-1:0]               dm_wdata,
    output logic [DW-1:0]               dm_rdata
);
    logic [DW-1:0] regs [bpe_pkg::NREG];
    logic [DW-1:0] ram  [DM_DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < bpe_pkg::NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (rf_we) begin
            regs[rf_sel] <= rf_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (dm_we) begin
            ram[dm_addr] <= dm_wdata;
        end
    end

    assign rf_rdata = regs[rf_sel];
    assign dm_rdata = ram[dm_addr];
endmodule

// File: rtl/bpe_alu.sv
module bpe_alu
    import bpe_pkg::*;
#(
    parameter int DW   = 8,
    localparam int SHW = $clog2(DW)
) (
    input  bpe_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] dm_val,
    output logic [DW-1:0] res,
    output logic          wr_acc
);
    logic [SHW-1:0]  amt;
    logic [2*DW-1:0] rol_w;
    logic [2*DW-1:0] ror_w;

    assign amt   = b[SHW-1:0];
    assign rol_w = {a, a} << amt;
    assign ror_w = {a, a} >> amt;

    always_comb begin
        res    = a;
        wr_acc = 1'b1;
        unique case (op)
            OP_MOV: res = b;
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_CEQ: res = (a == b) ? DW'(1) : '0;
            OP_SHL: res = a << amt;
            OP_SHR: res = a >> amt;
            OP_ROL: res = rol_w[2*DW-1:DW];
            OP_ROR: res = ror_w[DW-1:0];
            OP_RDR: res = rf_val;
            OP_RDM: res = dm_val;
            OP_NOP, OP_WRR, OP_WRM, OP_R14, OP_R15: wr_acc = 1'b0;
        endcase
    end
endmodule

// File: rtl/bpe_seq.sv
module bpe_seq
    import bpe_pkg::*;
#(
    parameter int PCW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           load_en,
    input  logic           mem_op,
    input  logic [PCW-1:0] end_idx,
    output logic [PCW-1:0] pc,
    output logic           commit,
    output bpe_state_e     st,
    output logic           busy
);
    bpe_state_e     st_d;
    logic [PCW-1:0] pc_d;
    logic           last;
    logic [PCW-1:0] pc_next;
    bpe_state_e     st_after;

    assign last     = (pc == end_idx);
    assign pc_next  = last ? '0 : pc + 1'b1;
    assign st_after = last ? ST_IDLE : ST_EXEC;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            pc <= '0;
        end else begin
            st <= st_d;
            pc <= pc_d;
        end
    end

    // transitions and outputs
    always_comb begin
        st_d   = st;
        pc_d   = pc;
        commit = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (load_en) begin
                    st_d = ST_LOAD;
                end else if (start) begin
                    st_d = ST_EXEC;
                    pc_d = '0;
                end
            end
            ST_LOAD: begin
                pc_d = '0;
                if (!load_en) st_d = ST_IDLE;
            end
            ST_EXEC: begin
                if (load_en) begin
                    st_d = ST_LOAD;
                    pc_d = '0;
                end else if (start) begin
                    pc_d = '0;
                end else if (mem_op) begin
                    st_d = ST_MEMW;
                end else begin
                    commit = 1'b1;
                    st_d   = st_after;
                    pc_d   = pc_next;
                end
            end
            ST_MEMW: begin
                if (load_en) begin
                    st_d = ST_LOAD;
                    pc_d = '0;
                end else if (start) begin
                    st_d = ST_EXEC;
                    pc_d = '0;
                end else begin
                    commit = 1'b1;
                    st_d   = st_after;
                    pc_d   = pc_next;
                end
            end
        endcase
    end

    assign busy = (st == ST_EXEC) || (st == ST_MEMW);
endmodule

// File: rtl/byte_pe.sv
module byte_pe
    import bpe_pkg::*;
#(
    parameter int DW         = 8,
    parameter int IM_DEPTH   = 256,
    parameter int DM_DEPTH   = 1024,
    localparam int IM_AW     = $clog2(IM_DEPTH),
    localparam int DM_AW     = $clog2(DM_DEPTH),
    localparam int LD_AW     = (DM_AW > IM_AW) ? DM_AW : IM_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [IM_AW-1:0]   end_idx,
    input  logic               load_en,
    input  logic               ld_we,
    input  logic               ld_tgt,
    input  logic [LD_AW-1:0]   ld_addr,
    input  logic [INSTR_W-1:0] ld_data,
    input  logic [DW-1:0]      nb_in0,
    input  logic [DW-1:0]      nb_in1,
    input  logic [DW-1:0]      nb_in2,
    output logic [DW-1:0]      nb_out,
    output logic               busy
);
    localparam int PAGE_W = DM_AW - IMM_W;

    logic [IM_AW-1:0]   pc;
    logic               commit;
    bpe_state_e         st;
    logic [INSTR_W-1:0] raw;
    bpe_instr_t         ins;
    logic               mem_op;
    logic [DW-1:0]      acc;
    logic [DW-1:0]      opb;
    logic [DW-1:0]      rf_rdata;
    logic [DW-1:0]      dm_rdata;
    logic [DW-1:0]      alu_res;
    logic               alu_wr;
    logic [DM_AW-1:0]   ex_addr;
    logic [DM_AW-1:0]   dm_addr;
    logic [DW-1:0]      dm_wdata;
    logic               dm_we;

    assign ins    = bpe_instr_t'(raw);
    assign mem_op = (ins.op == OP_RDM) || (ins.op == OP_WRM);

    bpe_seq #(.PCW(IM_AW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load_en (load_en),
        .mem_op  (mem_op),
        .end_idx (end_idx),
        .pc      (pc),
        .commit  (commit),
        .st      (st),
        .busy    (busy)
    );

    bpe_imem #(.DEPTH(IM_DEPTH)) u_imem (
        .clk   (clk),
        .we    (load_en & ld_we & ~ld_tgt),
        .waddr (ld_addr[IM_AW-1:0]),
        .wdata (ld_data),
        .raddr (pc),
        .rdata (raw)
    );

    always_comb begin
        unique case (ins.nsel)
            2'd0: opb = {{(DW-IMM_W){1'b0}}, ins.imm};
            2'd1: opb = nb_in0;
            2'd2: opb = nb_in1;
            2'd3: opb = nb_in2;
        endcase
    end

    assign ex_addr  = {rf_rdata[PAGE_W-1:0], ins.imm};
    assign dm_we    = (load_en & ld_we & ld_tgt) | (commit & (ins.op == OP_WRM));
    assign dm_addr  = load_en ? ld_addr[DM_AW-1:0] : ex_addr;
    assign dm_wdata = load_en ? ld_data[DW-1:0] : acc;

    bpe_store #(.DW(DW), .DM_DEPTH(DM_DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rf_we    (commit & (ins.op == OP_WRR)),
        .rf_sel   (ins.rsel),
        .rf_wdata (acc),
        .rf_rdata (rf_rdata),
        .dm_we    (dm_we),
        .dm_addr  (dm_addr),
        .dm_wdata (dm_wdata),
        .dm_rdata (dm_rdata)
    );

    bpe_alu #(.DW(DW)) u_alu (
        .op     (ins.op),
        .a      (acc),
        .b      (opb),
        .rf_val (rf_rdata),
        .dm_val (dm_rdata),
        .res    (alu_res),
        .wr_acc (alu_wr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (commit && alu_wr) begin
            acc <= alu_res;
        end
    end

    assign nb_out = acc;
endmodule

// File: rtl/byte_pe_chk.sv
module byte_pe_chk
    import bpe_pkg::*;
#(
    parameter int PCW = 8,
    parameter int DW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           load_en,
    input logic           busy,
    input logic           mem_op,
    input logic [PCW-1:0] pc,
    input logic [PCW-1:0] end_idx,
    input logic [DW-1:0]  nb_out,
    input bpe_state_e     st
);
    // R9 / R10: a start outside loading lands on slot 0 in EXEC
    p_start_slot0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !load_en) |=> (busy && pc == '0));

    // R11: loading halts execution
    p_load_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !busy);

    // R6: result latch holds while idle
    p_latch_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(nb_out));

    // R8: a RAM instruction stalls one cycle on the same slot
    p_ram_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXEC && !load_en && !start && mem_op) |=> (st == ST_MEMW && $stable(pc)));

    // R9: straight-line stepping, modulo buffer size
    p_pc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXEC && !load_en && !start && !mem_op && pc != end_idx)
        |=> (pc == PCW'($past(pc) + 1)));

    // R9: after the end slot the element idles at slot 0
    p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXEC && !load_en && !start && !mem_op && pc == end_idx)
        |=> (!busy && pc == '0));
endmodule

bind byte_pe byte_pe_chk #(.PCW(IM_AW), .DW(DW)) u_byte_pe_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .load_en (load_en),
    .busy    (busy),
    .mem_op  (mem_op),
    .pc      (pc),
    .end_idx (end_idx),
    .nb_out  (nb_out),
    .st      (st)
);

// File: tb/byte_pe_bench.sv
module byte_pe_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] MOV = 4'd1, AND_ = 4'd2, OR_ = 4'd3, XOR_ = 4'd4,
                           CEQ = 4'd5, SHL = 4'd6, SHR = 4'd7, ROL = 4'd8,
                           ROR = 4'd9, RDR = 4'd10, WRR = 4'd11, RDM = 4'd12,
                           WRM = 4'd13, NOP = 4'd0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  end_idx = '0;
    logic        load_en = 1'b0;
    logic        ld_we = 1'b0;
    logic        ld_tgt = 1'b0;
    logic [9:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [7:0]  nb_in0 = '0, nb_in1 = '0, nb_in2 = '0;
    logic [7:0]  nb_out;
    logic        busy;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_pe u_byte_pe (
        .clk(clk), .rst_n(rst_n), .start(start), .end_idx(end_idx),
        .load_en(load_en), .ld_we(ld_we), .ld_tgt(ld_tgt), .ld_addr(ld_addr),
        .ld_data(ld_data), .nb_in0(nb_in0), .nb_in1(nb_in1), .nb_in2(nb_in2),
        .nb_out(nb_out), .busy(busy)
    );

    function automatic logic [15:0] enc(logic [3:0] op, logic [2:0] r,
                                        logic [1:0] n, logic [6:0] imm);
        return {op, r, n, imm};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic open_load();
        @(negedge clk); load_en = 1'b1;
    endtask

    task automatic close_load();
        @(negedge clk); load_en = 1'b0; ld_we = 1'b0;
    endtask

    task automatic put(logic tgt, int addr, logic [15:0] data);
        @(negedge clk);
        ld_we = 1'b1; ld_tgt = tgt; ld_addr = 10'(addr); ld_data = data;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic run(int e, output int cyc);
        @(negedge clk);
        end_idx = 8'(e); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 2000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int c;
        chk("R1 nb_out after reset", nb_out, 8'h00);
        chk("R1 busy after reset", busy, 0);
        open_load();
        put(0, 0, enc(MOV, 0, 0, 7'h55));
        put(0, 1, enc(RDR, 6, 0, 0));
        close_load();
        run(1, c);
        chk("R1 register 6 reads zero", nb_out, 8'h00);
    endtask

    task automatic t_logic();
        int c;
        open_load();
        put(0, 0, enc(MOV, 0, 0, 7'h5A));
        put(0, 1, enc(AND_, 0, 0, 7'h0F));
        put(0, 2, enc(OR_, 0, 0, 7'h30));
        put(0, 3, enc(XOR_, 0, 0, 7'h7F));
        put(0, 4, enc(SHL, 0, 0, 7'd3));
        put(0, 5, enc(ROR, 0, 0, 7'd1));
        put(0, 6, enc(ROL, 0, 0, 7'd4));
        put(0, 7, enc(ROR, 0, 0, 7'd1));
        put(0, 8, enc(SHR, 0, 0, 7'd2));
        close_load();
        run(3, c);
        chk("R3 MOV/AND/OR/XOR chain", nb_out, 8'h45);
        chk("R9 cycles for 4 one-cycle instrs", c, 4);
        run(6, c);
        chk("R4 SHL/ROR/ROL chain", nb_out, 8'h41);
        run(8, c);
        chk("R4 ROR wrap then SHR", nb_out, 8'h28);
        chk("R9 cycles for 9 one-cycle instrs", c, 9);
    endtask

    task automatic t_ceq();
        int c;
        open_load();
        put(0, 0, enc(MOV, 0, 0, 7'h33));
        put(0, 1, enc(CEQ, 0, 0, 7'h33));
        close_load();
        run(1, c);
        chk("R5 compare equal", nb_out, 8'h01);
        open_load();
        put(0, 1, enc(CEQ, 0, 0, 7'h34));
        close_load();
        run(1, c);
        chk("R5 compare not equal", nb_out, 8'h00);
    endtask

    task automatic t_neigh();
        int c;
        nb_in0 = 8'hC3; nb_in1 = 8'h96; nb_in2 = 8'h5A;
        open_load();
        put(0, 0, enc(MOV, 0, 1, 0));
        put(0, 1, enc(XOR_, 0, 2, 0));
        put(0, 2, enc(AND_, 0, 3, 0));
        close_load();
        run(0, c);
        chk("R2 select 1 takes nb_in0", nb_out, 8'hC3);
        run(2, c);
        chk("R2 selects 2 and 3 take nb_in1/nb_in2", nb_out, 8'h50);
        nb_in0 = 8'h00;
        repeat (4) @(negedge clk);
        chk("R6 latch unchanged while idle", nb_out, 8'h50);
    endtask

    task automatic t_regfile();
        int c;
        open_load();
        put(0, 0, enc(MOV, 0, 0, 7'h11));
        put(0, 1, enc(WRR, 3, 0, 0));
        put(0, 2, enc(MOV, 0, 0, 7'h22));
        put(0, 3, enc(WRR, 5, 0, 0));
        put(0, 4, enc(MOV, 0, 0, 7'h00));
        put(0, 5, enc(RDR, 3, 0, 0));
        close_load();
        run(5, c);
        chk("R7 register 3 readback", nb_out, 8'h11);
        open_load();
        put(0, 5, enc(RDR, 5, 0, 0));
        close_load();
        run(5, c);
        chk("R7 register 5 readback", nb_out, 8'h22);
    endtask

    task automatic t_ram();
        int c;
        open_load();
        put(1, 10'h3F7, 16'h00E1);
        put(0, 0, enc(MOV, 0, 0, 7'h07));
        put(0, 1, enc(WRR, 2, 0, 0));
        put(0, 2, enc(RDM, 2, 0, 7'h77));
        close_load();
        run(2, c);
        chk("R11 RAM preload read via page 7", nb_out, 8'hE1);
        chk("R8 two non-RAM + one RAM instr cycles", c, 4);
        open_load();
        put(0, 0, enc(MOV, 0, 0, 7'h02));
        put(0, 1, enc(WRR, 1, 0, 0));
        put(0, 2, enc(MOV, 0, 0, 7'h6C));
        put(0, 3, enc(WRM, 1, 0, 7'h15));
        put(0, 4, enc(MOV, 0, 0, 7'h00));
        put(0, 5, enc(RDM, 1, 0, 7'h15));
        close_load();
        run(5, c);
        chk("R8 RAM store then load", nb_out, 8'h6C);
        chk("R8 cycles with two RAM instrs", c, 8);
    endtask

    task automatic t_nop();
        int c;
        open_load();
        put(0, 0, enc(MOV, 0, 0, 7'h3C));
        put(0, 1, enc(NOP, 0, 0, 7'h7F));
        put(0, 2, enc(4'd14, 0, 0, 7'h7F));
        put(0, 3, enc(4'd15, 0, 0, 7'h7F));
        close_load();
        run(3, c);
        chk("R12 nop and reserved keep latch", nb_out, 8'h3C);
    endtask

    task automatic t_restart();
        int c;
        open_load();
        put(0, 0, enc(MOV, 0, 0, 7'h01));
        for (int i = 1; i <= 5; i++) put(0, i, enc(SHL, 0, 0, 7'd1));
        close_load();
        @(negedge clk); end_idx = 8'd5; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        run(5, c);
        chk("R10 restart runs full program", c, 6);
        chk("R10 restart result", nb_out, 8'h20);
    endtask

    task automatic t_halt();
        logic [7:0] held;
        @(negedge clk); end_idx = 8'd5; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        load_en = 1'b1;
        @(negedge clk);
        chk("R11 busy drops under load_en", busy, 0);
        held = nb_out;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 start ignored while loading", busy, 0);
        chk("R11 latch halted while loading", nb_out, held);
        close_load();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_logic();
        t_ceq();
        t_neigh();
        t_regfile();
        t_ram();
        t_nop();
        t_restart();
        t_halt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule